// File: doc/BRIEF.md
# Programmable Time Pulse Generator

This block produces the time-pulse output (TP), a periodic data-out pulse and a once-per-second counting tick. Its time base is a clock enable that fires at the crystal tick rate, 2^SEC_LOG2 times per second. The default of 15 gives 32.768 kHz. A four-bit command, qualified by a one-cycle valid strobe, selects what TP does. TP can be a square wave at one of four fixed audio-range rates, or a slow square wave whose period is 1, 10, 30 or 60 seconds. The other commands are register hold, shift, time read, time set and test entry. Each of these applies its own override to TP, to the data-out pulse, and to whether the seconds tick runs.

A free-running prescaler counts tick enables and emits the seconds tick when it wraps. A time-set command clears the six most significant stages of this prescaler, so the sub-second phase restarts. The calendar counters and the shift register are built elsewhere. They use `sec_tick` and the commands, but they are outside this block. The variant parameter selects between a serial-capable part and a basic part. The two variants differ only in the data-out rate during time read.

Top module: `pulse_rate_gen`

## Requirements
- R1: Command codes 4, 5, 6 and 7 select a TP square wave at 64, 256, 2048 and 4096 Hz. Each half-period lasts 2^SEC_LOG2/(2·f) ticks, with a minimum of one tick. A command restarts the wave: TP is high from the command edge for one full half-period and then toggles after every further half-period.
- R2: Command codes 8, 9, 10 and 11 select TP square waves with periods of 1, 10, 30 and 60 seconds. They restart in the same way as in R1.
- R3: Code 0 (register hold) sets TP to 64 Hz. It also starts a 1 Hz square wave on `dout_pulse` that begins high.
- R4: In test state, code 1 (shift) and code 3 (time read) set TP to 32 Hz. Outside test state these codes leave the TP wave and its phase untouched.
- R5: In test state, code 2 (time set) stops TP and holds it low.
- R6: Code 2 clears the six most significant prescaler stages and keeps the lower stages. It also stops `sec_tick` until counting is enabled again.
- R7: Code 3 starts a square wave on `dout_pulse`. The serial-capable variant runs it at 1 Hz. The basic variant runs it at 0.5 Hz outside test state and at 512 Hz in test state.
- R8: Code 15 enters test state and stops `sec_tick`. Code 0 and codes 4 to 11 leave test state and enable `sec_tick`. Codes 1 and 3 enable `sec_tick` only outside test state.
- R9: Codes 1, 2 and 15 stop `dout_pulse` and hold it low.
- R10: While counting is enabled, `sec_tick` pulses high for one cycle every 2^SEC_LOG2 tick enables. Cycles without a tick enable advance nothing.
- R11: Codes 12, 13 and 14 have no effect on any output.
- R12: Reset drives `tp`, `dout_pulse` and `sec_tick` low. After reset both waves are stopped, counting is enabled and test state is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the crystal tick rate |
| cmd_valid | input | 1 | Qualifies `cmd` for one cycle |
| cmd | input | 4 | Command code |
| tp | output | 1 | Time-pulse square wave |
| dout_pulse | output | 1 | Periodic data-out pulse |
| sec_tick | output | 1 | One-cycle pulse per second of ticks |

## Verification
The bench sweeps every rate command over two prescaler sizes. It checks each TP sample against the half-period computed from the rate, so an off-by-one limit or a restart that begins low shows up at the first toggle. It enters and leaves test state with shift, time-read and time-set commands. A design that forgot the test flag, or never cleared it on a rate command, would therefore run TP at the wrong rate or leave it stuck low. A time set is issued half a second after a seconds tick, and the next tick is expected a full second later. A prescaler that was not cleared would tick after about half a second. Unused codes are issued in the middle of a running wave to expose a stray restart.

// File: rtl/tpg_pkg.sv
// Shared command codes and half-period arithmetic for the time pulse generator.
// Assumes the tick rate is a power of two, 2**s ticks per second.
package tpg_pkg;

    localparam logic [3:0] CMD_HOLD  = 4'd0;
    localparam logic [3:0] CMD_SHIFT = 4'd1;
    localparam logic [3:0] CMD_TSET  = 4'd2;
    localparam logic [3:0] CMD_TREAD = 4'd3;
    localparam logic [3:0] CMD_F64   = 4'd4;
    localparam logic [3:0] CMD_F256  = 4'd5;
    localparam logic [3:0] CMD_F2K   = 4'd6;
    localparam logic [3:0] CMD_F4K   = 4'd7;
    localparam logic [3:0] CMD_I1    = 4'd8;
    localparam logic [3:0] CMD_I10   = 4'd9;
    localparam logic [3:0] CMD_I30   = 4'd10;
    localparam logic [3:0] CMD_I60   = 4'd11;
    localparam logic [3:0] CMD_TEST  = 4'd15;

    // Half-period in ticks of a 2**f_log2 Hz wave, never below one tick.
    function automatic int unsigned half_ticks(int s, int f_log2);
        int e;
        e = s - f_log2 - 1;
        return (e <= 0) ? 1 : (32'd1 << e);
    endfunction

    // Half-period in ticks of a wave whose period is secs seconds.
    function automatic int unsigned interval_half(int s, int secs);
        return (secs * (32'd1 << s)) / 2;
    endfunction

endpackage

// File: rtl/tpg_prescale.sv
// Seconds prescaler: counts tick enables and pulses sec_tick_o on wrap
// while counting is enabled. A phase clear zeroes the top six stages.
// Assumes S >= 6.
module tpg_prescale #(
    parameter int S = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic count_en_i,
    input  logic phase_clr_i,
    output logic sec_tick_o
);
    localparam logic [S-1:0] ALL_ONES = {S{1'b1}};
    localparam logic [S-1:0] LOW_MASK = {S{1'b1}} >> 6;

    logic [S-1:0] div_q;
    logic [S-1:0] div_nxt;

    // Next divider value before any phase clear.
    always_comb div_nxt = div_q + {{(S-1){1'b0}}, tick_i};

    // Divider state and registered seconds pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q      <= '0;
            sec_tick_o <= 1'b0;
        end else begin
            sec_tick_o <= tick_i && count_en_i && (div_q == ALL_ONES);
            div_q      <= phase_clr_i ? (div_nxt & LOW_MASK) : div_nxt;
        end
    end

    AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        phase_clr_i |=> ((div_q & ~LOW_MASK) == '0));                          // R6
    AST_SEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_o |=> !sec_tick_o);                                            // R10
    AST_SEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en_i |=> !sec_tick_o);                                           // R6

endmodule

// File: rtl/tpg_square.sv
// Restartable square-wave generator: a load with run_i set restarts the
// wave high with a new half-period limit; a load without it stops low.
// Assumes lim_i holds half-period minus one, in ticks.
module tpg_square #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic          run_i,
    input  logic [CW-1:0] lim_i,
    output logic          wave_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;
    logic          run_q;

    // Load, stop or advance the half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= '0;
            run_q  <= 1'b0;
            wave_o <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= '0;
            lim_q  <= lim_i;
            run_q  <= run_i;
            wave_o <= run_i;
        end else if (run_q && tick_i) begin
            if (cnt_q == lim_q) begin
                cnt_q  <= '0;
                wave_o <= ~wave_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= lim_q));                                            // R1
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !run_i) |=> !wave_o);                                        // R5
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(wave_o));                              // R10

endmodule

// File: rtl/tpg_mode_ctrl.sv
// Command decoder: turns each strobed command into load requests for the
// TP and data-out generators, and keeps the test and count-enable state.
// Assumes commands arrive as one-cycle strobes.
module tpg_mode_ctrl
    import tpg_pkg::*;
#(
    parameter int S      = 15,
    parameter int CW     = 20,
    parameter bit SERIAL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid_i,
    input  logic [3:0]    cmd_i,
    output logic          tp_load_o,
    output logic          tp_run_o,
    output logic [CW-1:0] tp_lim_o,
    output logic          do_load_o,
    output logic          do_run_o,
    output logic [CW-1:0] do_lim_o,
    output logic          phase_clr_o,
    output logic          count_en_o
);
    localparam int unsigned H_F64  = half_ticks(S, 6);
    localparam int unsigned H_F256 = half_ticks(S, 8);
    localparam int unsigned H_F2K  = half_ticks(S, 11);
    localparam int unsigned H_F4K  = half_ticks(S, 12);
    localparam int unsigned H_T32  = half_ticks(S, 5);
    localparam int unsigned H_512  = half_ticks(S, 9);
    localparam int unsigned H_1HZ  = half_ticks(S, 0);
    localparam int unsigned H_HHZ  = half_ticks(S, -1);
    localparam int unsigned H_I1   = interval_half(S, 1);
    localparam int unsigned H_I10  = interval_half(S, 10);
    localparam int unsigned H_I30  = interval_half(S, 30);
    localparam int unsigned H_I60  = interval_half(S, 60);

    function automatic logic [CW-1:0] to_lim(int unsigned h);
        return CW'(h - 1);
    endfunction

    logic test_q, test_nxt;
    logic cnt_en_q, cnt_en_nxt;
    logic rate_sel;

    // Rate-select commands (fixed or interval) share one behaviour.
    always_comb rate_sel = cmd_valid_i && (cmd_i >= CMD_F64) && (cmd_i <= CMD_I60);

    // Decode the strobed command into generator loads and state updates.
    always_comb begin
        tp_load_o   = 1'b0;
        tp_run_o    = 1'b0;
        tp_lim_o    = '0;
        do_load_o   = 1'b0;
        do_run_o    = 1'b0;
        do_lim_o    = '0;
        phase_clr_o = 1'b0;
        test_nxt    = test_q;
        cnt_en_nxt  = cnt_en_q;
        if (cmd_valid_i) begin
            case (cmd_i)
                CMD_HOLD: begin
                    tp_load_o  = 1'b1;
                    tp_run_o   = 1'b1;
                    tp_lim_o   = to_lim(H_F64);
                    do_load_o  = 1'b1;
                    do_run_o   = 1'b1;
                    do_lim_o   = to_lim(H_1HZ);
                    test_nxt   = 1'b0;
                    cnt_en_nxt = 1'b1;
                end
                CMD_SHIFT: begin
                    tp_load_o  = test_q;
                    tp_run_o   = 1'b1;
                    tp_lim_o   = to_lim(H_T32);
                    do_load_o  = 1'b1;
                    cnt_en_nxt = cnt_en_q | ~test_q;
                end
                CMD_TSET: begin
                    tp_load_o   = test_q;
                    do_load_o   = 1'b1;
                    phase_clr_o = 1'b1;
                    cnt_en_nxt  = 1'b0;
                end
                CMD_TREAD: begin
                    tp_load_o  = test_q;
                    tp_run_o   = 1'b1;
                    tp_lim_o   = to_lim(H_T32);
                    do_load_o  = 1'b1;
                    do_run_o   = 1'b1;
                    do_lim_o   = SERIAL ? to_lim(H_1HZ)
                                        : (test_q ? to_lim(H_512) : to_lim(H_HHZ));
                    cnt_en_nxt = cnt_en_q | ~test_q;
                end
                CMD_F64, CMD_F256, CMD_F2K, CMD_F4K,
                CMD_I1, CMD_I10, CMD_I30, CMD_I60: begin
                    tp_load_o  = 1'b1;
                    tp_run_o   = 1'b1;
                    case (cmd_i)
                        CMD_F64:  tp_lim_o = to_lim(H_F64);
                        CMD_F256: tp_lim_o = to_lim(H_F256);
                        CMD_F2K:  tp_lim_o = to_lim(H_F2K);
                        CMD_F4K:  tp_lim_o = to_lim(H_F4K);
                        CMD_I1:   tp_lim_o = to_lim(H_I1);
                        CMD_I10:  tp_lim_o = to_lim(H_I10);
                        CMD_I30:  tp_lim_o = to_lim(H_I30);
                        default:  tp_lim_o = to_lim(H_I60);
                    endcase
                    test_nxt   = 1'b0;
                    cnt_en_nxt = 1'b1;
                end
                CMD_TEST: begin
                    do_load_o  = 1'b1;
                    test_nxt   = 1'b1;
                    cnt_en_nxt = 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Test and count-enable state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q   <= 1'b0;
            cnt_en_q <= 1'b1;
        end else begin
            test_q   <= test_nxt;
            cnt_en_q <= cnt_en_nxt;
        end
    end

    always_comb count_en_o = cnt_en_q;

    AST_TSET_STOPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_i == CMD_TSET) |=> !cnt_en_q);                      // R6
    AST_RATE_LEAVES_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        rate_sel |=> (!test_q && cnt_en_q));                                    // R8
    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_i == CMD_TEST) |=> (test_q && !cnt_en_q));          // R8
    AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_i inside {4'd12, 4'd13, 4'd14}) |=> $stable(test_q)); // R11

endmodule

// File: rtl/pulse_rate_gen.sv
// Top of the time pulse generator: command decoder, seconds prescaler and
// two square-wave generators (TP and data-out) sharing the tick enable.
// Assumes SEC_LOG2 >= 6 and that tick_en is a one-cycle enable.
module pulse_rate_gen #(
    parameter int SEC_LOG2       = 15,
    parameter bit SERIAL_VARIANT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       cmd_valid,
    input  logic [3:0] cmd,
    output logic       tp,
    output logic       dout_pulse,
    output logic       sec_tick
);
    localparam int CW = SEC_LOG2 + 5;

    logic          tp_load, tp_run, do_load, do_run, phase_clr, count_en;
    logic [CW-1:0] tp_lim, do_lim;

    tpg_mode_ctrl #(.S(SEC_LOG2), .CW(CW), .SERIAL(SERIAL_VARIANT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
        .tp_load_o(tp_load), .tp_run_o(tp_run), .tp_lim_o(tp_lim),
        .do_load_o(do_load), .do_run_o(do_run), .do_lim_o(do_lim),
        .phase_clr_o(phase_clr), .count_en_o(count_en)
    );

    tpg_prescale #(.S(SEC_LOG2)) u_prescale (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .count_en_i(count_en),
        .phase_clr_i(phase_clr), .sec_tick_o(sec_tick)
    );

    tpg_square #(.CW(CW)) u_tp_wave (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .load_i(tp_load),
        .run_i(tp_run), .lim_i(tp_lim), .wave_o(tp)
    );

    tpg_square #(.CW(CW)) u_do_wave (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .load_i(do_load),
        .run_i(do_run), .lim_i(do_lim), .wave_o(dout_pulse)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tp && !dout_pulse && !sec_tick));                          // R12

endmodule

// File: tb/pulse_rate_gen_bench.sv
// Bench: instance A is the basic variant with 2**13 ticks/s (fixed rates),
// instance B is the serial variant with 2**6 ticks/s (second intervals).
module pulse_rate_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic sparse = 1'b0;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd = 4'd0;
    logic tp_a, dout_a, sec_a, tp_b, dout_b, sec_b;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tick_en <= sparse ? ~tick_en : 1'b1;

    pulse_rate_gen #(.SEC_LOG2(13), .SERIAL_VARIANT(1'b0)) u_pulse_rate_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmd_valid(cmd_valid),
        .cmd(cmd), .tp(tp_a), .dout_pulse(dout_a), .sec_tick(sec_a));

    pulse_rate_gen #(.SEC_LOG2(6), .SERIAL_VARIANT(1'b1)) u_pulse_rate_gen_b (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmd_valid(cmd_valid),
        .cmd(cmd), .tp(tp_b), .dout_pulse(dout_b), .sec_tick(sec_b));

    function automatic logic pick(int sel);
        case (sel)
            0: return tp_a;
            1: return dout_a;
            2: return tp_b;
            3: return dout_b;
            4: return sec_a;
            default: return sec_b;
        endcase
    endfunction

    task automatic report(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the command edge.
    task automatic send(input logic [3:0] code);
        cmd = code;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Sample n is expected high when ((n+off)/half) is even.
    task automatic chk_wave(input int sel, input int half, input int len,
                            input int off, input string tag);
        int bad_n = -1;
        int bad_v = 0;
        int bad_e = 0;
        for (int n = 0; n < len; n++) begin
            logic e;
            e = (((n + off) / half) % 2) == 0;
            if (bad_n < 0 && pick(sel) !== e) begin
                bad_n = n;
                bad_v = int'(pick(sel));
                bad_e = int'(e);
            end
            @(negedge clk);
        end
        report(bad_n < 0, $sformatf("%s sample %0d", tag, bad_n), bad_v, bad_e);
    endtask

    task automatic chk_const(input int sel, input logic val, input int len, input string tag);
        int bad = 0;
        for (int n = 0; n < len; n++) begin
            if (pick(sel) !== val) bad++;
            @(negedge clk);
        end
        report(bad == 0, tag, bad, 0);
    endtask

    task automatic wait_rise(input int sel, input int maxc, output int c);
        c = 0;
        while (pick(sel) !== 1'b1 && c < maxc) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        int c;
        int c2;
        repeat (3) @(negedge clk);
        // R12: outputs low in and after reset
        report({tp_a, dout_a, sec_a, tp_b, dout_b, sec_b} == 6'b0, "R12 in reset",
               int'({tp_a, dout_a, sec_a, tp_b, dout_b, sec_b}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        report({tp_a, dout_a, sec_a, tp_b, dout_b, sec_b} == 6'b0, "R12 after reset",
               int'({tp_a, dout_a, sec_a, tp_b, dout_b, sec_b}), 0);

        // R10: seconds period with continuous and sparse ticks
        wait_rise(5, 200, c); @(negedge clk); wait_rise(5, 200, c2);
        report(c2 + 1 == 64, "R10 sec period B", c2 + 1, 64);
        wait_rise(4, 9000, c); @(negedge clk); wait_rise(4, 9000, c2);
        report(c2 + 1 == 8192, "R10 sec period A", c2 + 1, 8192);
        sparse = 1'b1;
        repeat (3) @(negedge clk);
        wait_rise(5, 300, c); @(negedge clk); wait_rise(5, 300, c2);
        report(c2 + 1 == 128, "R10 sparse ticks B", c2 + 1, 128);
        sparse = 1'b0;
        repeat (2) @(negedge clk);

        // R1: fixed rates on A
        for (int k = 0; k < 4; k++) begin
            int h;
            h = (k == 0) ? 64 : (k == 1) ? 16 : (k == 2) ? 2 : 1;
            send(4'(4 + k));
            chk_wave(0, h, 4 * h + 4, 0, $sformatf("R1 code %0d", 4 + k));
        end

        // R2: second intervals on B (64 ticks per second)
        for (int k = 0; k < 4; k++) begin
            int h;
            h = (k == 0) ? 32 : (k == 1) ? 320 : (k == 2) ? 960 : 1920;
            send(4'(8 + k));
            chk_wave(2, h, 2 * h + 4, 0, $sformatf("R2 code %0d", 8 + k));
        end

        // R3: register hold
        send(4'd0); chk_wave(0, 64, 260, 0, "R3 hold tp");
        send(4'd0); chk_wave(1, 4096, 8200, 0, "R3 hold dout");

        // R11: unused code mid-wave
        send(4'd0); chk_wave(3, 32, 10, 0, "R11 before");
        send(4'd13); chk_wave(3, 32, 100, 11, "R11 dout undisturbed");

        // R8/R9: test entry
        send(4'd15); chk_const(1, 1'b0, 40, "R9 test dout low");
        chk_const(5, 1'b0, 200, "R8 test stops sec_tick");
        // R4: shift in test
        send(4'd1); chk_wave(0, 128, 520, 0, "R4 shift test tp");
        // R7: time read in test
        send(4'd3); chk_wave(1, 8, 40, 0, "R7 basic test read");
        send(4'd3); chk_wave(3, 32, 100, 0, "R7 serial read");
        send(4'd3); chk_wave(0, 128, 300, 0, "R4 read test tp");
        // R5: time set in test
        send(4'd2); chk_const(0, 1'b0, 300, "R5 test tset tp low");
        send(4'd2); chk_const(1, 1'b0, 20, "R9 tset dout low");

        // R8: rate command leaves test; shift then leaves TP alone
        send(4'd4); chk_wave(0, 64, 20, 0, "R8 exit test");
        send(4'd1); chk_wave(0, 64, 200, 21, "R4 shift normal tp");
        wait_rise(5, 70, c);
        report(c < 70, "R8 sec_tick resumed", c, 64);

        // R7: basic time read outside test
        send(4'd3); chk_wave(1, 8192, 16390, 0, "R7 basic read");

        // R6: time set stops counting and clears prescaler phase
        send(4'd2); chk_const(4, 1'b0, 9000, "R6 no sec_tick");
        send(4'd4); wait_rise(4, 8300, c);
        report(c < 8300, "R8 count re-enabled", c, 8192);
        @(negedge clk);
        repeat (4096) @(negedge clk);
        send(4'd2);
        send(4'd4);
        wait_rise(4, 9000, c);
        report(c + 1 >= 8060 && c + 1 <= 8195, "R6 phase restart", c + 1, 8128);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule